// File: doc/BRIEF.md
# Pixel Hit Timestamp Buffer

This block is the digital memory behind one pixel, or one group of pixels, in a sensor that gives a one-bit hit decision and runs in bunch trains. At every beam-crossing strobe it samples the discriminator bit. A crossing counter tracks the crossing number. Only when the pixel is hit does the current crossing number go into a small local memory. Crossings without a hit cost no storage. The depth of that memory is a parameter, chosen from the expected hit rate.

While a train is running, results only accumulate. Once the train-end pulse arrives, writes stop. The stored crossing numbers then leave through a ready/valid port in the order they were recorded, followed by one status word that holds the hit count and a sticky overflow flag. The block is emptied by the next train-start pulse. A train-start that arrives before readout is complete raises a busy error and throws the unread data away.

The controller has three states. `ST_IDLE` holds no data. `ST_ACQ` is accumulation during a train. `ST_READ` is readout. The transitions are:
- IDLE to ACQ on train start.
- ACQ to ACQ on train start, which restarts the train.
- ACQ to READ on train end.
- READ to IDLE on the status-word handshake.
- READ to ACQ on train start, which raises the busy error.
- IDLE stays IDLE on train end.

Top module: `pix_hit_tsbuf`

## Requirements
- R1: After reset, `rd_valid_o` and `busy_err_o` are 0 and the block is idle.
- R2: The k-th crossing strobe after a train start (k counted from 0) that carries `hit_i`=1 stores the value k, zero-extended to 16 bits.
- R3: Crossings with `hit_i`=0 store nothing, so the status count equals the number of hit crossings that were accepted.
- R4: Readout delivers stored entries oldest first, one word per cycle with `rd_valid_o` and `rd_ready_i` both high. While ready is low, valid and data hold steady.
- R5: After the last entry, one status word follows: bit 15 is the overflow flag and bits 14:0 are the number of stored entries.
- R6: A hit that arrives with DEPTH entries already stored is dropped, and the overflow flag is set for the rest of the train.
- R7: The crossing counter covers 0 to MAX_XING-1. Strobes after MAX_XING crossings in a train are ignored, record nothing and do not wrap.
- R8: `rd_valid_o` stays 0 while a train is accumulating.
- R9: A train start during readout sets `busy_err_o`, discards the unread data and starts a fresh train. A train start outside readout clears `busy_err_o`.
- R10: After the status-word handshake, `rd_valid_o` drops to 0. A train-end pulse while idle has no effect.
- R11: A train start during accumulation restarts the train with an empty buffer and the crossing counter at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| train_start_i | input | 1 | One-cycle pulse: empty the buffer and begin a train |
| train_end_i | input | 1 | One-cycle pulse: stop writing and begin readout |
| xing_strobe_i | input | 1 | One-cycle pulse per beam crossing |
| hit_i | input | 1 | Discriminator result, sampled with the strobe |
| rd_ready_i | input | 1 | Readout consumer ready |
| rd_valid_o | output | 1 | Readout word valid |
| rd_data_o | output | 16 | Readout word: crossing number or status |
| busy_err_o | output | 1 | Train started before readout finished |

## Verification
The bench builds the block with DEPTH=4 and MAX_XING=12, instead of the defaults of 8 and 5000. With these values a short train can fill the memory and overflow it, and can also run the crossing counter to its limit. Random trains of 0 to 17 crossings therefore cross both boundaries often, and directed trains pin each boundary down exactly. Random ready back-pressure exercises the hold behaviour of the readout port.

// File: rtl/pix_hit_tsbuf_pkg.sv
package pix_hit_tsbuf_pkg;
    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_READ = 2'd2
    } tsb_state_e;
endpackage

// File: rtl/pix_hit_tsbuf_xctr.sv
module pix_hit_tsbuf_xctr #(
    parameter int MAX_XING = 5000,
    localparam int XW = $clog2(MAX_XING + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          step_i,
    output logic [XW-1:0] value_o,
    output logic          live_o
);
    localparam logic [XW-1:0] LIMIT = XW'(MAX_XING);

    logic [XW-1:0] cnt_q;

    assign live_o  = (cnt_q < LIMIT);
    assign value_o = cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (step_i && live_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pix_hit_tsbuf_store.sv
module pix_hit_tsbuf_store
    import pix_hit_tsbuf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              wr_en_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [IW-1:0]     rd_idx_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic [CW-1:0]     fill_o,
    output logic              ovf_o
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [WORD_W-1:0] mem_q [DEPTH];
    logic [CW-1:0]     fill_q;
    logic              ovf_q;
    logic              full;

    assign full      = (fill_q == FULL);
    assign fill_o    = fill_q;
    assign ovf_o     = ovf_q;
    assign rd_data_o = mem_q[rd_idx_i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fill_q <= '0;
            ovf_q  <= 1'b0;
        end else if (clr_i) begin
            fill_q <= '0;
            ovf_q  <= 1'b0;
        end else if (wr_en_i) begin
            if (full) begin
                ovf_q <= 1'b1;
            end else begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (wr_en_i && !clr_i && !full && (fill_q == CW'(g))) begin
                mem_q[g] <= wr_data_i;
            end
        end
    end
endmodule

// File: rtl/pix_hit_tsbuf.sv
module pix_hit_tsbuf
    import pix_hit_tsbuf_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int MAX_XING = 5000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              train_start_i,
    input  logic              train_end_i,
    input  logic              xing_strobe_i,
    input  logic              hit_i,
    input  logic              rd_ready_i,
    output logic              rd_valid_o,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              busy_err_o
);
    localparam int XW = $clog2(MAX_XING + 1);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    tsb_state_e        state_q, state_d;
    logic [CW-1:0]     rd_ptr_q;
    logic              busy_q;
    logic [XW-1:0]     xing_w;
    logic              live_w;
    logic [CW-1:0]     fill_w;
    logic              ovf_w;
    logic [WORD_W-1:0] entry_w;
    logic              sample;
    logic              take;
    logic              at_status;

    assign sample    = (state_q == ST_ACQ) && xing_strobe_i && live_w && !train_start_i;
    assign at_status = (rd_ptr_q == fill_w);
    assign take      = (state_q == ST_READ) && rd_ready_i && !train_start_i;

    pix_hit_tsbuf_xctr #(.MAX_XING(MAX_XING)) u_xctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (train_start_i),
        .step_i  (sample),
        .value_o (xing_w),
        .live_o  (live_w)
    );

    pix_hit_tsbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clr_i     (train_start_i),
        .wr_en_i   (sample && hit_i),
        .wr_data_i (WORD_W'(xing_w)),
        .rd_idx_i  (rd_ptr_q[IW-1:0]),
        .rd_data_o (entry_w),
        .fill_o    (fill_w),
        .ovf_o     (ovf_w)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state selection; train start has priority everywhere
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (train_start_i) state_d = ST_ACQ;
            ST_ACQ: begin
                if (train_start_i)    state_d = ST_ACQ;
                else if (train_end_i) state_d = ST_READ;
            end
            ST_READ: begin
                if (train_start_i)          state_d = ST_ACQ;
                else if (take && at_status) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // read pointer and busy-error flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_ptr_q <= '0;
            busy_q   <= 1'b0;
        end else begin
            if (train_start_i) begin
                rd_ptr_q <= '0;
                busy_q   <= (state_q == ST_READ);
            end else if (take && !at_status) begin
                rd_ptr_q <= rd_ptr_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        rd_valid_o = (state_q == ST_READ);
        busy_err_o = busy_q;
        if (at_status) begin
            rd_data_o = {ovf_w, (WORD_W-1)'(fill_w)};
        end else begin
            rd_data_o = entry_w;
        end
    end
endmodule

// File: rtl/pix_hit_tsbuf_chk.sv
module pix_hit_tsbuf_chk
    import pix_hit_tsbuf_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int MAX_XING = 5000,
    localparam int XW = $clog2(MAX_XING + 1),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              train_start,
    input logic              rd_ready,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_data,
    input logic              busy_err,
    input tsb_state_e        state,
    input logic [CW-1:0]     fill,
    input logic [XW-1:0]     xing
);
    p_quiet_in_train_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACQ) |-> !rd_valid);

    p_hold_on_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready && !train_start) |=> (rd_valid && $stable(rd_data)));

    p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    p_ctr_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xing <= XW'(MAX_XING));

    p_busy_on_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && train_start) |=> busy_err);

    p_fresh_train_r11: assert property (@(posedge clk) disable iff (!rst_n)
        train_start |=> (fill == '0 && xing == '0 && state == ST_ACQ));
endmodule

bind pix_hit_tsbuf pix_hit_tsbuf_chk #(.DEPTH(DEPTH), .MAX_XING(MAX_XING)) chk_i (
    .clk         (clk_i),
    .rst_n       (rst_ni),
    .train_start (train_start_i),
    .rd_ready    (rd_ready_i),
    .rd_valid    (rd_valid_o),
    .rd_data     (rd_data_o),
    .busy_err    (busy_err_o),
    .state       (state_q),
    .fill        (fill_w),
    .xing        (xing_w)
);

// File: tb/pix_hit_tsbuf_tb_top.sv
module pix_hit_tsbuf_tb_top;
    localparam int DEPTH    = 4;
    localparam int MAX_XING = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        train_start = 1'b0;
    logic        train_end = 1'b0;
    logic        xing_strobe = 1'b0;
    logic        hit = 1'b0;
    logic        rd_ready = 1'b0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        busy_err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench reference model
    int          m_k;
    int          m_n;
    bit          m_ovf;
    logic [15:0] exp_q[$];

    always #4 clk = ~clk;

    pix_hit_tsbuf #(.DEPTH(DEPTH), .MAX_XING(MAX_XING)) dut_i (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .train_start_i (train_start),
        .train_end_i   (train_end),
        .xing_strobe_i (xing_strobe),
        .hit_i         (hit),
        .rd_ready_i    (rd_ready),
        .rd_valid_o    (rd_valid),
        .rd_data_o     (rd_data),
        .busy_err_o    (busy_err)
    );

    function automatic logic [15:0] status_word(int n, bit ovf);
        return {ovf, 15'(n)};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_train();
        @(negedge clk) train_start = 1'b1;
        m_k = 0; m_n = 0; m_ovf = 1'b0;
        exp_q.delete();
        @(negedge clk) train_start = 1'b0;
    endtask

    task automatic crossing(bit h);
        @(negedge clk) begin xing_strobe = 1'b1; hit = h; end
        if (m_k < MAX_XING) begin
            if (h) begin
                if (m_n < DEPTH) begin
                    exp_q.push_back(16'(m_k));
                    m_n++;
                end else begin
                    m_ovf = 1'b1;
                end
            end
            m_k++;
        end
        @(negedge clk) begin xing_strobe = 1'b0; hit = 1'b0; end
    endtask

    task automatic end_train();
        @(negedge clk) train_end = 1'b1;
        exp_q.push_back(status_word(m_n, m_ovf));
        @(negedge clk) train_end = 1'b0;
    endtask

    task automatic drain(string req);
        int idx = 0;
        int guard = 0;
        while (idx < exp_q.size() && guard < 500) begin
            bit rdy;
            @(negedge clk);
            guard++;
            rdy = ($urandom % 3) != 0;
            check("R4", 32'(rd_valid), 32'd1);
            if (rdy && rd_valid) begin
                check((idx == exp_q.size() - 1) ? "R5" : req, 32'(rd_data), 32'(exp_q[idx]));
                idx++;
            end
            rd_ready = rdy;
        end
        @(negedge clk) rd_ready = 1'b0;
        check("R10", 32'(rd_valid), 32'd0);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL R4 watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", 32'(rd_valid), 32'd0);
        check("R1", 32'(busy_err), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 32'(rd_valid), 32'd0);

        // R10: train end while idle does nothing
        @(negedge clk) train_end = 1'b1;
        @(negedge clk) train_end = 1'b0;
        check("R10", 32'(rd_valid), 32'd0);

        // R2 / R3: mixed hits, R8: no readout mid-train
        start_train();
        crossing(0); crossing(1); crossing(0); crossing(0); crossing(1);
        check("R8", 32'(rd_valid), 32'd0);
        end_train();
        drain("R2");

        // R3: no hits at all
        start_train();
        for (int i = 0; i < 5; i++) crossing(0);
        end_train();
        drain("R3");

        // R6: overflow
        start_train();
        for (int i = 0; i < 6; i++) crossing(1);
        end_train();
        drain("R6");

        // R7: counter limit, hits beyond MAX_XING crossings ignored
        start_train();
        for (int i = 0; i < 10; i++) crossing(0);
        for (int i = 0; i < 4; i++) crossing(1);
        end_train();
        drain("R7");

        // R11: restart during accumulation
        start_train();
        crossing(1); crossing(1);
        start_train();
        crossing(0); crossing(1);
        end_train();
        drain("R11");

        // R9: train start during readout
        start_train();
        crossing(1); crossing(1);
        end_train();
        @(negedge clk) rd_ready = 1'b1;
        @(negedge clk) rd_ready = 1'b0;
        start_train();
        check("R9", 32'(busy_err), 32'd1);
        check("R9", 32'(rd_valid), 32'd0);
        crossing(0); crossing(1);
        end_train();
        drain("R9");
        start_train();
        check("R9", 32'(busy_err), 32'd0);
        end_train();
        drain("R9");

        // random trains
        for (int t = 0; t < 25; t++) begin
            int n;
            n = $urandom % 18;
            start_train();
            for (int i = 0; i < n; i++) crossing(($urandom % 3) == 0);
            end_train();
            drain("R2");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule